// File: doc/BRIEF.md
# Bus Window Control Registers

This block is the control register bank of a bus bridge, paired with the address translation it drives. The bank holds eight 32-bit words: three inbound-map words, three secondary-map words, an identity word and a flags word. Software reaches them through a single-beat register port. An access to a location that does not exist, or an access narrower than a full word, is reported through an error flag.

The translation half opens three memory windows onto a 32-bit downstream address space. A window select and an offset within that window produce a downstream address. The window base comes from the matching inbound-map word, and the way it is formed depends on a variant select input. In variant A, the low nibble of the map word becomes the top four address bits. In variant B, the map word is used with the bits below the window size cleared. Each variant has its own set of window sizes. An offset that falls outside the selected window raises a range flag.

Issuing the downstream transactions is not part of this block.

Top module: `bwin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all eight stored words read as zero, and reg_rdata and reg_err are 0.
- R2: Word offsets are 0x00, 0x04 and 0x08 for inbound maps 0 to 2, 0x0C for the identity word, 0x10 for flags, and 0x14, 0x18 and 0x1C for secondary maps 0 to 2. A read request drives the stored word on reg_rdata with reg_err 0 in the cycle after the request. A write response is data 0 with reg_err 0.
- R3: An access at any other offset (not a multiple of four, or 0x20 and above) sets reg_err in the response cycle, returns 0 and changes no stored word.
- R4: An access whose byte enable is not 4'hF sets reg_err, returns 0 and changes no stored word.
- R5: In variant A (variant_b=0), the base of window w is the low four bits of inbound map w placed at address bits 31:28, with all other map bits ignored.
- R6: In variant B (variant_b=1), the base of window w is inbound map w with every bit below the window size cleared.
- R7: xl_addr equals the window base plus win_off, truncated to 32 bits. This holds even when the offset is out of range.
- R8: xl_range_err is 1 when win_off is at or above the window size, and 0 otherwise. The sizes are 0x0C000000, 0x10000000 and 0x10000000 in variant A, and 0x01000000, 0x04000000 and 0x08000000 in variant B.
- R9: A window select of 3 gives xl_range_err 1 and xl_addr 0.
- R10: A write to an inbound map changes translation from the clock edge that accepts it. Before that edge, xl_addr still shows the old base.
- R11: Writes to the secondary maps, the identity word and the flags word leave translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_en | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_be | input | 4 | Byte enables; only 4'hF is legal |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after the request |
| reg_err | output | 1 | Bad offset or partial access, registered with reg_rdata |
| variant_b | input | 1 | 0 = nibble-placed base, 1 = size-masked base |
| win_sel | input | 2 | Window number, 0 to 2 |
| win_off | input | 32 | Offset inside the selected window |
| xl_addr | output | 32 | Translated downstream address |
| xl_range_err | output | 1 | Offset outside window, or bad window |

## Verification
The assertions assume that every input changes away from the rising edge and stays steady across it. They also assume that each variant B window size is a power of two, since otherwise the aligned-base property would be meaningless. The bench drives all stimulus on the falling edge and samples translation results one time unit later. Register responses are sampled shortly after the rising edge that registers them. The bench uses only the default power-of-two sizes for variant B, and it holds reset for several cycles before the first access.

// File: rtl/bwin_pkg.sv
// Shared types for the bus window control block.
// Assumes a fixed set of three memory windows, matching the register layout.
package bwin_pkg;
    localparam int NWIN   = 3;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Word index = byte offset / 4; the order is fixed by the register layout
    typedef enum logic [2:0] {
        IDX_IMAP0  = 3'd0,
        IDX_IMAP1  = 3'd1,
        IDX_IMAP2  = 3'd2,
        IDX_SELFID = 3'd3,
        IDX_FLAGS  = 3'd4,
        IDX_SMAP0  = 3'd5,
        IDX_SMAP1  = 3'd6,
        IDX_SMAP2  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/bwin_regs.sv
// Register bank: eight 32-bit words behind a single-beat access port.
// Decodes word offsets, rejects misaligned, out-of-map and partial accesses,
// and registers the read response one cycle after the request.
// Assumes ADDR_W > 5 and synchronous active-low reset.
module bwin_regs
    import bwin_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  acc_we,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [3:0]            acc_be,
    input  word_t                 acc_wdata,
    output word_t                 rd_data,
    output logic                  rd_err,
    output logic [NWIN-1:0][WORD_W-1:0] imap_o
);
    logic [NWIN-1:0][WORD_W-1:0] imap_q;
    logic [NWIN-1:0][WORD_W-1:0] smap_q;
    word_t    selfid_q;
    word_t    flags_q;
    logic     hit;
    logic     full;
    logic     ok;
    reg_idx_e idx;
    word_t    rd_mux;

    // Offset decode: word aligned and inside the eight-word map
    assign hit  = (acc_addr[1:0] == 2'b00) && (acc_addr[ADDR_W-1:5] == '0);
    assign full = &acc_be;
    assign ok   = hit && full;
    assign idx  = reg_idx_e'(acc_addr[4:2]);

    // Storage update on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imap_q   <= '0;
            smap_q   <= '0;
            selfid_q <= '0;
            flags_q  <= '0;
        end else if (acc_en && acc_we && ok) begin
            case (idx)
                IDX_IMAP0:  imap_q[0] <= acc_wdata;
                IDX_IMAP1:  imap_q[1] <= acc_wdata;
                IDX_IMAP2:  imap_q[2] <= acc_wdata;
                IDX_SELFID: selfid_q  <= acc_wdata;
                IDX_FLAGS:  flags_q   <= acc_wdata;
                IDX_SMAP0:  smap_q[0] <= acc_wdata;
                IDX_SMAP1:  smap_q[1] <= acc_wdata;
                IDX_SMAP2:  smap_q[2] <= acc_wdata;
                default:    ;
            endcase
        end
    end

    // Read selection by word index
    always_comb begin
        case (idx)
            IDX_IMAP0:  rd_mux = imap_q[0];
            IDX_IMAP1:  rd_mux = imap_q[1];
            IDX_IMAP2:  rd_mux = imap_q[2];
            IDX_SELFID: rd_mux = selfid_q;
            IDX_FLAGS:  rd_mux = flags_q;
            IDX_SMAP0:  rd_mux = smap_q[0];
            IDX_SMAP1:  rd_mux = smap_q[1];
            IDX_SMAP2:  rd_mux = smap_q[2];
            default:    rd_mux = '0;
        endcase
    end

    // Registered response: data for good reads, error for rejected accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else if (acc_en) begin
            rd_data <= (!acc_we && ok) ? rd_mux : '0;
            rd_err  <= !ok;
        end else begin
            rd_data <= '0;
            rd_err  <= 1'b0;
        end
    end

    assign imap_o = imap_q;

    // R1: storage is clear on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imap_q == '0) && (smap_q == '0) && (selfid_q == '0) && (flags_q == '0));

    // R3: a write at an unmapped offset leaves every word untouched
    p_badoff_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && !hit) |=> $stable(imap_q) && $stable(smap_q)
                                        && $stable(selfid_q) && $stable(flags_q));

    // R4: a partial write leaves every word untouched
    p_partial_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && !full) |=> $stable(imap_q) && $stable(smap_q)
                                        && $stable(selfid_q) && $stable(flags_q));

    // R4: a partial access is answered with the error flag and zero data
    p_partial_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !full) |=> rd_err && (rd_data == '0));
endmodule

// File: rtl/bwin_xlate.sv
// Window translation: forms each window base from its inbound map word per
// the variant select, then adds the in-window offset for the selected window.
// Assumes variant B sizes are powers of two; variant A sizes only bound range.
module bwin_xlate
    import bwin_pkg::*;
#(
    parameter logic [NWIN-1:0][WORD_W-1:0] SIZE_A = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
    parameter logic [NWIN-1:0][WORD_W-1:0] SIZE_B = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000},
    parameter int SEL_W = 2
) (
    input  logic [NWIN-1:0][WORD_W-1:0] imap_i,
    input  logic                        variant_b,
    input  logic [SEL_W-1:0]            win_sel,
    input  word_t                       win_off,
    output word_t                       xl_addr,
    output logic                        xl_range_err
);
    logic [NWIN-1:0][WORD_W-1:0] base_w;
    logic [NWIN-1:0][WORD_W-1:0] size_w;
    word_t base_s;
    word_t size_s;
    logic  valid_s;

    // Per-window base and size for the chosen variant
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        always_comb begin
            size_w[w] = variant_b ? SIZE_B[w] : SIZE_A[w];
            base_w[w] = variant_b ? (imap_i[w] & ~(SIZE_B[w] - 32'd1))
                                  : {imap_i[w][3:0], 28'd0};
        end
    end

    // Window selection; select values past the last window are invalid
    always_comb begin
        base_s  = '0;
        size_s  = '0;
        valid_s = 1'b0;
        for (int w = 0; w < NWIN; w++) begin
            if (win_sel == SEL_W'(w)) begin
                base_s  = base_w[w];
                size_s  = size_w[w];
                valid_s = 1'b1;
            end
        end
    end

    // Offset add and range check
    always_comb begin
        xl_addr      = valid_s ? (base_s + win_off) : '0;
        xl_range_err = !valid_s || (win_off >= size_s);
    end
endmodule

// File: rtl/bwin_ctrl.sv
// Top of the bus window control block: register bank plus window translation.
// The inbound maps leave the bank as flops, so a map write reaches xl_addr
// from the accepting clock edge. Inputs are expected to be steady at the edge.
module bwin_ctrl
    import bwin_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [NWIN-1:0][WORD_W-1:0] SIZE_A = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
    parameter logic [NWIN-1:0][WORD_W-1:0] SIZE_B = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic              variant_b,
    input  logic [1:0]        win_sel,
    input  logic [31:0]       win_off,
    output logic [31:0]       xl_addr,
    output logic              xl_range_err
);
    localparam int SEL_W = 2;

    logic [NWIN-1:0][WORD_W-1:0] imap;

    bwin_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (reg_en),
        .acc_we    (reg_we),
        .acc_addr  (reg_addr),
        .acc_be    (reg_be),
        .acc_wdata (reg_wdata),
        .rd_data   (reg_rdata),
        .rd_err    (reg_err),
        .imap_o    (imap)
    );

    bwin_xlate #(.SIZE_A(SIZE_A), .SIZE_B(SIZE_B), .SEL_W(SEL_W)) u_xlate (
        .imap_i       (imap),
        .variant_b    (variant_b),
        .win_sel      (win_sel),
        .win_off      (win_off),
        .xl_addr      (xl_addr),
        .xl_range_err (xl_range_err)
    );

    // R5: in variant A the base has no bits below bit 28
    p_var_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!variant_b && !xl_range_err) |-> (((xl_addr - win_off) & 32'h0FFF_FFFF) == 32'd0));

    // R6: in variant B the base is aligned to the selected window size
    for (genvar w = 0; w < NWIN; w++) begin : g_chk
        p_var_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (variant_b && !xl_range_err && win_sel == SEL_W'(w))
                |-> (((xl_addr - win_off) & (SIZE_B[w] - 32'd1)) == 32'd0));
    end
endmodule

// File: tb/sim_bwin_ctrl.sv
module sim_bwin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = 4'hF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic        variant_b = 1'b0;
    logic [1:0]  win_sel = '0;
    logic [31:0] win_off = '0;
    logic [31:0] xl_addr;
    logic        xl_range_err;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    logic [31:0] m_reg [8];

    always #4 clk = ~clk;

    bwin_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .variant_b(variant_b),
        .win_sel(win_sel), .win_off(win_off), .xl_addr(xl_addr),
        .xl_range_err(xl_range_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: one response per request, registered on the request's edge
    always @(posedge clk) begin
        if (rst_n && reg_en) begin
            #2;
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard-underflow", reg_rdata, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(reg_rdata == e.data, {e.req, " data"}, reg_rdata, e.data);
                chk(reg_err == e.err, {e.req, " err"}, {31'd0, reg_err}, {31'd0, e.err});
            end
        end
    end

    // Driver: one access, expected response computed from the model
    task automatic acc(input logic [7:0] a, input bit we, input logic [3:0] be,
                       input logic [31:0] wd, input string req);
        exp_t e;
        bit good;
        good = (a[1:0] == 2'b00) && (a < 8'h20) && (be == 4'hF);
        e.req  = req;
        e.err  = !good;
        e.data = (good && !we) ? m_reg[a[4:2]] : 32'd0;
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_be = be; reg_wdata = wd;
        sb_q.push_back(e);
        if (good && we) m_reg[a[4:2]] = wd;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; reg_be = 4'hF;
    endtask

    function automatic logic [31:0] win_size(input bit vb, input int w);
        if (vb) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
        else    return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
    endfunction

    function automatic logic [31:0] win_base(input bit vb, input int w);
        if (vb) return m_reg[w] & ~(win_size(1'b1, w) - 32'd1);
        else    return {m_reg[w][3:0], 28'd0};
    endfunction

    task automatic xchk(input bit vb, input logic [1:0] sel, input logic [31:0] off, input string req);
        logic [31:0] ea;
        bit er;
        if (sel == 2'd3) begin ea = 32'd0; er = 1'b1; end
        else begin
            ea = win_base(vb, int'(sel)) + off;
            er = (off >= win_size(vb, int'(sel)));
        end
        @(negedge clk);
        variant_b = vb; win_sel = sel; win_off = off;
        #1;
        chk(xl_addr == ea, {req, " addr"}, xl_addr, ea);
        chk(xl_range_err == er, {req, " range"}, {31'd0, xl_range_err}, {31'd0, er});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] hold;
        for (int i = 0; i < 8; i++) m_reg[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(reg_rdata == 32'd0 && reg_err == 1'b0, "R1 response idle", reg_rdata, 32'd0);
        for (int i = 0; i < 8; i++) acc(8'(i * 4), 1'b0, 4'hF, 32'd0, "R1 reset read");

        // R2: fill every word with a distinct value and read back
        for (int i = 0; i < 8; i++) acc(8'(i * 4), 1'b1, 4'hF, 32'hA500_0000 ^ (32'h0103_0507 * (i + 1)), "R2 write");
        for (int i = 0; i < 8; i++) acc(8'(i * 4), 1'b0, 4'hF, 32'd0, "R2 read");

        // R3: bad offsets
        acc(8'h20, 1'b0, 4'hF, 32'd0, "R3 read 0x20");
        acc(8'h02, 1'b0, 4'hF, 32'd0, "R3 read misaligned");
        acc(8'hFC, 1'b1, 4'hF, 32'hDEAD_BEEF, "R3 write 0xFC");
        acc(8'h05, 1'b1, 4'hF, 32'hDEAD_BEEF, "R3 write misaligned");
        for (int i = 0; i < 8; i++) acc(8'(i * 4), 1'b0, 4'hF, 32'd0, "R3 words unchanged");

        // R4: partial accesses
        acc(8'h00, 1'b1, 4'h3, 32'h1234_5678, "R4 partial write");
        acc(8'h10, 1'b1, 4'hE, 32'h1234_5678, "R4 partial write flags");
        acc(8'h0C, 1'b0, 4'h1, 32'd0, "R4 partial read");
        acc(8'h00, 1'b0, 4'hF, 32'd0, "R4 word unchanged");
        acc(8'h10, 1'b0, 4'hF, 32'd0, "R4 flags unchanged");

        // R5/R7/R8: variant A
        acc(8'h00, 1'b1, 4'hF, 32'hFFFF_FFF5, "R5 map0");
        acc(8'h04, 1'b1, 4'hF, 32'h0000_000A, "R5 map1");
        acc(8'h08, 1'b1, 4'hF, 32'h1234_567F, "R5 map2");
        xchk(1'b0, 2'd0, 32'h0000_0123, "R5 window0");
        xchk(1'b0, 2'd1, 32'h0FFF_FFFF, "R7 window1 top");
        xchk(1'b0, 2'd0, 32'h0BFF_FFFF, "R8 A last in range");
        xchk(1'b0, 2'd0, 32'h0C00_0000, "R8 A first out of range");
        xchk(1'b0, 2'd1, 32'h1000_0000, "R8 A window1 out");
        xchk(1'b0, 2'd2, 32'h2000_0000, "R7 wrap out of range");
        chk(xl_addr == 32'h1000_0000, "R7 wrap value", xl_addr, 32'h1000_0000);

        // R6/R7/R8: variant B
        acc(8'h00, 1'b1, 4'hF, 32'h1234_5678, "R6 map0");
        acc(8'h04, 1'b1, 4'hF, 32'hABCD_EF01, "R6 map1");
        acc(8'h08, 1'b1, 4'hF, 32'hFFFF_FFFF, "R6 map2");
        xchk(1'b1, 2'd0, 32'h0000_0040, "R6 window0");
        chk(xl_addr == 32'h1200_0040, "R6 window0 value", xl_addr, 32'h1200_0040);
        xchk(1'b1, 2'd1, 32'h0000_0010, "R6 window1");
        chk(xl_addr == 32'hA800_0010, "R6 window1 value", xl_addr, 32'hA800_0010);
        xchk(1'b1, 2'd2, 32'h07FF_FFFF, "R8 B window2 last");
        xchk(1'b1, 2'd0, 32'h00FF_FFFF, "R8 B window0 last");
        xchk(1'b1, 2'd0, 32'h0100_0000, "R8 B window0 out");
        xchk(1'b1, 2'd1, 32'h0400_0000, "R8 B window1 out");

        // R9: invalid window
        xchk(1'b0, 2'd3, 32'h0000_0004, "R9 select 3 A");
        xchk(1'b1, 2'd3, 32'h0000_0000, "R9 select 3 B");

        // R10: map write takes effect at the accepting edge
        xchk(1'b0, 2'd0, 32'h0000_0100, "R10 before");
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h00; reg_be = 4'hF; reg_wdata = 32'h0000_0007;
        begin
            exp_t e;
            e.data = 32'd0; e.err = 1'b0; e.req = "R10 write";
            sb_q.push_back(e);
        end
        #1;
        chk(xl_addr == 32'h8000_0100, "R10 old base before edge", xl_addr, 32'h8000_0100);
        @(posedge clk);
        #1;
        m_reg[0] = 32'h0000_0007;
        chk(xl_addr == 32'h7000_0100, "R10 new base after edge", xl_addr, 32'h7000_0100);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;

        // R11: non-map words do not steer translation
        xchk(1'b1, 2'd1, 32'h0000_0080, "R11 before");
        hold = xl_addr;
        acc(8'h0C, 1'b1, 4'hF, 32'hFFFF_FFFF, "R11 selfid write");
        acc(8'h10, 1'b1, 4'hF, 32'hFFFF_FFFF, "R11 flags write");
        acc(8'h14, 1'b1, 4'hF, 32'hFFFF_FFFF, "R11 smap0 write");
        acc(8'h18, 1'b1, 4'hF, 32'hFFFF_FFFF, "R11 smap1 write");
        acc(8'h1C, 1'b1, 4'hF, 32'hFFFF_FFFF, "R11 smap2 write");
        #1;
        chk(xl_addr == hold && xl_range_err == 1'b0, "R11 translation unchanged", xl_addr, hold);
        acc(8'h18, 1'b0, 4'hF, 32'd0, "R11 smap1 stored");

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'd0);
        summary();
        $finish;
    end
endmodule